// File: doc/BRIEF.md
# Disk Command Validation Sequencer

This block sits between the control-register write path of a disk controller and the engine that performs seeks and transfers. When software writes a command with the GO bit set, the block checks the selected drive's state against the requested function code. It reports at most one failure, the most important one. The command then either starts or ends at once with an error bit, the error and DONE flags, and for some failures a drive-attention request.

All checks are combinational and resolve in the cycle of the write. Every result is registered, so outputs change on the next clock edge. The two instantaneous functions (no-operation and drive clear) are dispatched without holding GO. Every other accepted function holds GO until the operation engine pulses `op_finish`.

Function codes: 0 no-op, 1 pack acknowledge, 2 drive clear, 3 unload, 4 spin-up, 5 recalibrate, 6 offset, 7 seek, 8 read, 9 write, 10 read headers, 11 write headers, 12 write check, 13 to 15 unsupported. Error vector `err_bits` positions: 0 no drive, 1 programming, 2 format, 3 drive type, 4 not executable, 5 unsafe, 6 seek incomplete, 7 illegal address, 8 operation incomplete, 9 illegal function.

Top module: `disk_cmd_check`

## Requirements
- R1: After reset, `done` is 1. `go`, `err`, `start`, `attn` and `drv_int` are 0, and `err_bits` is 0.
- R2: A GO command to a drive with `drv_present`=0 sets bit 0 (no drive), `err` and `done`, and does not start. This check outranks every other check on the command.
- R3: If no higher check fails and `fmt_bit`=1, the command sets bit 2 (format) with `err`/`done` and does not start.
- R4: Functions 1 and 3 to 12 fail with bit 3 (drive type) when `type_req`≠`drv_type`. Functions 0 and 2 are still dispatched, pulsing `start` with `done` kept at 1, and then report bit 3. Codes 13 to 15 skip this check.
- R5: Functions 5 to 12 on a drive with `drv_vv`=0 set bit 4 (not executable), pulse `attn` and set `drv_int`.
- R6: Functions 1 and 3 to 12 on a drive with `drv_loaded`=0 set bit 5 (unsafe), pulse `attn` and set `drv_int`.
- R7: Functions 1 and 3 to 12 to a busy drive (`drv_busy`=1) are ignored: no start, no error, and no flag changes.
- R8: Functions 7 to 12 with `cyl`≥`cyl_lim` or `surf`≥`surf_lim` set bits 6 and 7 together and do not start.
- R9: Functions 8 to 12 with `sect`≥`sect_lim` set bit 8 (operation incomplete) and do not start.
- R10: Codes 13 to 15 set bit 9 (illegal function) when no earlier check fails.
- R11: A command that passes all checks pulses `start` and clears `drv_int`. For functions 1 and 3 to 12 it also sets `go` and clears `done` until `op_finish`, which clears `go` and sets `done`.
- R12: Any register write while `go`=1 that is not a clear sets bit 1 (programming), `err` and `done`, and clears `go`.
- R13: A clear write clears `err_bits`, `go` and `drv_int` and sets `done`, even when GO is also written.
- R14: A GO write while `err`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_go | input | 1 | Write carries GO=1 |
| reg_clr | input | 1 | Write is a controller or subsystem clear |
| op_finish | input | 1 | Operation engine completion pulse |
| fn | input | 4 | Function code |
| type_req | input | 1 | Requested drive type |
| fmt_bit | input | 1 | Alternate format selected |
| drv_present | input | 1 | Selected drive exists |
| drv_loaded | input | 1 | Drive loaded |
| drv_vv | input | 1 | Volume valid |
| drv_busy | input | 1 | Drive busy |
| drv_type | input | 1 | Actual drive type |
| cyl | input | CYL_W | Requested cylinder |
| cyl_lim | input | CYL_W | Cylinder count of the drive |
| surf | input | SURF_W | Requested surface |
| surf_lim | input | SURF_W | Surface count |
| sect | input | SECT_W | Requested sector |
| sect_lim | input | SECT_W | Sector count |
| start | output | 1 | One-cycle dispatch pulse |
| go | output | 1 | Command in progress |
| done | output | 1 | Controller done flag |
| err | output | 1 | Any error bit set |
| attn | output | 1 | One-cycle drive-attention pulse |
| drv_int | output | 1 | Drive interrupt flag |
| err_bits | output | 10 | Sticky error bits |

## Verification
Every result of a write, clear or finish strobe is due on the first rising edge after the strobe. This includes the start and attention pulses, which last exactly that one cycle. The bench's reference model updates on that same edge from the same inputs. Both sides are compared at the falling edge of each cycle, so a result a cycle early, a cycle late, or a pulse a cycle too long is caught.

// File: rtl/disk_cmd_check.sv
module disk_cmd_check #(
  parameter int CYL_W  = 10,
  parameter int SURF_W = 3,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_go,
  input  logic              reg_clr,
  input  logic              op_finish,
  input  logic [3:0]        fn,
  input  logic              type_req,
  input  logic              fmt_bit,
  input  logic              drv_present,
  input  logic              drv_loaded,
  input  logic              drv_vv,
  input  logic              drv_busy,
  input  logic              drv_type,
  input  logic [CYL_W-1:0]  cyl,
  input  logic [CYL_W-1:0]  cyl_lim,
  input  logic [SURF_W-1:0] surf,
  input  logic [SURF_W-1:0] surf_lim,
  input  logic [SECT_W-1:0] sect,
  input  logic [SECT_W-1:0] sect_lim,
  output logic              start,
  output logic              go,
  output logic              done,
  output logic              err,
  output logic              attn,
  output logic              drv_int,
  output logic [9:0]        err_bits
);
  localparam int E_NED = 0, E_PGE = 1, E_FMT = 2, E_DTY = 3, E_NXF = 4;
  localparam int E_UNS = 5, E_SKI = 6, E_IAE = 7, E_OPI = 8, E_ILF = 9;
  localparam logic [3:0] F_NOP = 4'd0, F_DCLR = 4'd2, F_LAST = 4'd12;

  logic       known, instant, need_type, need_vv, need_cyl, need_sect, type_bad;
  logic       ignore, late_dty, attn_req;
  logic [9:0] chk_err;

  assign known     = fn <= F_LAST;
  assign instant   = (fn == F_NOP) || (fn == F_DCLR);
  assign need_type = known && !instant;
  assign need_vv   = known && (fn >= 4'd5);
  assign need_cyl  = known && (fn >= 4'd7);
  assign need_sect = known && (fn >= 4'd8);
  assign type_bad  = type_req != drv_type;

  always_comb begin
    chk_err  = '0;
    ignore   = 1'b0;
    late_dty = 1'b0;
    if (!drv_present)                                         chk_err[E_NED] = 1'b1;
    else if (fmt_bit)                                         chk_err[E_FMT] = 1'b1;
    else if (need_type && type_bad)                           chk_err[E_DTY] = 1'b1;
    else if (need_vv && !drv_vv)                              chk_err[E_NXF] = 1'b1;
    else if (need_type && !drv_loaded)                        chk_err[E_UNS] = 1'b1;
    else if (need_type && drv_busy)                           ignore = 1'b1;
    else if (need_cyl && (cyl >= cyl_lim || surf >= surf_lim)) begin
      chk_err[E_SKI] = 1'b1;
      chk_err[E_IAE] = 1'b1;
    end
    else if (need_sect && sect >= sect_lim)                   chk_err[E_OPI] = 1'b1;
    else if (!known)                                          chk_err[E_ILF] = 1'b1;
    else if (instant && type_bad)                             late_dty = 1'b1;
  end

  assign attn_req = chk_err[E_NXF] || chk_err[E_UNS];
  assign err      = |err_bits;

  logic cmd, clr, prog_err;
  assign clr      = reg_wr && reg_clr;
  assign prog_err = reg_wr && !reg_clr && go;
  assign cmd      = reg_wr && reg_go && !reg_clr && !go && !err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_bits <= '0;
      go       <= 1'b0;
      done     <= 1'b1;
      start    <= 1'b0;
      attn     <= 1'b0;
      drv_int  <= 1'b0;
    end else begin
      start <= 1'b0;
      attn  <= 1'b0;
      if (clr) begin
        err_bits <= '0;
        go       <= 1'b0;
        done     <= 1'b1;
        drv_int  <= 1'b0;
      end else if (prog_err) begin
        err_bits[E_PGE] <= 1'b1;
        go              <= 1'b0;
        done            <= 1'b1;
      end else if (cmd) begin
        if (chk_err != '0) begin
          err_bits <= err_bits | chk_err;
          done     <= 1'b1;
          attn     <= attn_req;
          if (attn_req) drv_int <= 1'b1;
        end else if (!ignore) begin
          start   <= 1'b1;
          drv_int <= 1'b0;
          if (!instant) begin
            go   <= 1'b1;
            done <= 1'b0;
          end
          if (late_dty) err_bits[E_DTY] <= 1'b1;
        end
      end else if (op_finish && go) begin
        go   <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  AST_GO_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !done);  // R11
  AST_ATTN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    attn |-> ((err_bits[E_NXF] || err_bits[E_UNS]) && drv_int));  // R5
  AST_PGE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_clr && go) |=> (err_bits[E_PGE] && done && !go));  // R12
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_clr) |=> (!err && done && !go && !drv_int));  // R13
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_go && !reg_clr && err) |=> !start);  // R14
  AST_NED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_go && !reg_clr && !go && !err && !drv_present) |=> (err_bits[E_NED] && !start));  // R2
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_go && !reg_clr && !go && !err && drv_present && !fmt_bit && drv_busy &&
     drv_loaded && drv_vv && !type_bad && fn != F_NOP && fn != F_DCLR && fn <= F_LAST)
    |=> (!start && !attn && $stable(err_bits)));  // R7
endmodule

// File: tb/disk_cmd_check_tb.sv
module disk_cmd_check_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, reg_wr, reg_go, reg_clr, op_finish;
  logic [3:0] fn;
  logic type_req, fmt_bit, drv_present, drv_loaded, drv_vv, drv_busy, drv_type;
  logic [9:0] cyl, cyl_lim;
  logic [2:0] surf, surf_lim;
  logic [4:0] sect, sect_lim;
  logic start, go, done, err, attn, drv_int;
  logic [9:0] err_bits;

  disk_cmd_check u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_go(reg_go), .reg_clr(reg_clr),
    .op_finish(op_finish), .fn(fn), .type_req(type_req), .fmt_bit(fmt_bit),
    .drv_present(drv_present), .drv_loaded(drv_loaded), .drv_vv(drv_vv),
    .drv_busy(drv_busy), .drv_type(drv_type), .cyl(cyl), .cyl_lim(cyl_lim),
    .surf(surf), .surf_lim(surf_lim), .sect(sect), .sect_lim(sect_lim),
    .start(start), .go(go), .done(done), .err(err), .attn(attn),
    .drv_int(drv_int), .err_bits(err_bits));

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  int m_bits;
  bit m_go, m_done, m_start, m_attn, m_int;

  always @(posedge clk) begin
    bit t, v, c, s, known, inst;
    int code;
    bit skip, late;
    if (!rst_n) begin
      m_bits <= 0; m_go <= 0; m_done <= 1; m_start <= 0; m_attn <= 0; m_int <= 0;
    end else begin
      m_start <= 0; m_attn <= 0;
      t = 0; v = 0; c = 0; s = 0; known = 1; inst = 0;
      case (fn)
        4'd0, 4'd2: inst = 1;
        4'd1, 4'd3, 4'd4: t = 1;
        4'd5, 4'd6: begin t = 1; v = 1; end
        4'd7: begin t = 1; v = 1; c = 1; end
        4'd8, 4'd9, 4'd10, 4'd11, 4'd12: begin t = 1; v = 1; c = 1; s = 1; end
        default: known = 0;
      endcase
      code = 0; skip = 0; late = 0;
      if (!drv_present) code = 1;
      else if (fmt_bit) code = 4;
      else if (t && type_req != drv_type) code = 8;
      else if (v && !drv_vv) code = 16;
      else if (t && !drv_loaded) code = 32;
      else if (t && drv_busy) skip = 1;
      else if (c && (cyl >= cyl_lim || surf >= surf_lim)) code = 64 + 128;
      else if (s && sect >= sect_lim) code = 256;
      else if (!known) code = 512;
      else if (inst && type_req != drv_type) late = 1;

      if (reg_wr && reg_clr) begin
        m_bits <= 0; m_go <= 0; m_done <= 1; m_int <= 0;
      end else if (reg_wr && m_go) begin
        m_bits <= m_bits | 2; m_go <= 0; m_done <= 1;
      end else if (reg_wr && reg_go && m_bits == 0) begin
        if (code != 0) begin
          m_bits <= m_bits | code; m_done <= 1;
          if (code == 16 || code == 32) begin m_attn <= 1; m_int <= 1; end
        end else if (!skip) begin
          m_start <= 1; m_int <= 0;
          if (!inst) begin m_go <= 1; m_done <= 0; end
          if (late) m_bits <= m_bits | 8;
        end
      end else if (op_finish && m_go) begin
        m_go <= 0; m_done <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if ({start, go, done, err, attn, drv_int, err_bits} !==
          {m_start, m_go, m_done, (m_bits != 0), m_attn, m_int, m_bits[9:0]}) begin
        fails++;
        $display("FAIL %s: start/go/done/err/attn/int/bits actual %b%b%b%b%b%b %h expected %b%b%b%b%b%b %h",
                 cur_req, start, go, done, err, attn, drv_int, err_bits,
                 m_start, m_go, m_done, (m_bits != 0), m_attn, m_int, m_bits[9:0]);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_wr(bit g, bit c);
    @(negedge clk);
    reg_wr = 1; reg_go = g; reg_clr = c;
    @(negedge clk);
    reg_wr = 0; reg_go = 0; reg_clr = 0;
    idle(2);
  endtask

  task automatic cmd(logic [3:0] f);
    fn = f;
    pulse_wr(1, 0);
  endtask

  task automatic finish_op;
    @(negedge clk); op_finish = 1;
    @(negedge clk); op_finish = 0;
    idle(1);
  endtask

  task automatic nominal;
    type_req = 0; drv_type = 0; fmt_bit = 0; drv_present = 1; drv_loaded = 1;
    drv_vv = 1; drv_busy = 0; cyl = 10'd100; surf = 3'd1; sect = 5'd5;
  endtask

  task automatic clear_all;
    pulse_wr(0, 1);
    nominal();
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_go = 0; reg_clr = 0; op_finish = 0; fn = 0;
    cyl_lim = 10'd815; surf_lim = 3'd3; sect_lim = 5'd22;
    nominal();
    idle(3);
    rst_n = 1;
    cur_req = "R1"; idle(3);

    cur_req = "R11"; cmd(4'd8); idle(2); finish_op();
    cmd(4'd0); cmd(4'd1); finish_op();

    cur_req = "R12"; cmd(4'd7); pulse_wr(0, 0);
    cur_req = "R13"; clear_all();
    cmd(4'd9); fn = 4'd9; pulse_wr(1, 1);

    cur_req = "R2"; drv_present = 0; fmt_bit = 1; drv_type = 1; cmd(4'd8); clear_all();
    cur_req = "R3"; fmt_bit = 1; drv_type = 1; cmd(4'd9); clear_all();

    cur_req = "R4"; drv_type = 1; cmd(4'd9); clear_all();
    drv_type = 1; cmd(4'd2); clear_all();
    drv_type = 1; cmd(4'd0); clear_all();
    drv_type = 1; cmd(4'd14); clear_all();

    cur_req = "R5"; drv_vv = 0; cmd(4'd7); clear_all();
    drv_vv = 0; cmd(4'd1); finish_op(); clear_all();

    cur_req = "R6"; drv_loaded = 0; cmd(4'd3); clear_all();
    drv_loaded = 0; drv_vv = 0; cmd(4'd12); clear_all();

    cur_req = "R7"; drv_busy = 1; cmd(4'd8); cmd(4'd0); clear_all();

    cur_req = "R8"; cyl = 10'd815; cmd(4'd7); clear_all();
    cyl = 10'd814; surf = 3'd3; cmd(4'd9); clear_all();
    cyl = 10'd1000; cmd(4'd5); finish_op(); clear_all();
    cyl = 10'd814; surf = 3'd2; cmd(4'd7); finish_op();

    cur_req = "R9"; sect = 5'd22; cmd(4'd8); clear_all();
    sect = 5'd21; cmd(4'd12); finish_op();
    sect = 5'd30; cmd(4'd7); finish_op(); clear_all();

    cur_req = "R10"; cmd(4'd13); clear_all(); cmd(4'd15); clear_all();

    cur_req = "R14"; cmd(4'd13); cmd(4'd8); cmd(4'd0); clear_all();
    cmd(4'd8); finish_op();

    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule